// File: doc/BRIEF.md
# Single-Pixel Frame Dump Register

This block lets a slow host pull a whole image out of a fast pixel stream through one 8-bit register. The stream carries 6-bit pixel values with a frame-start marker, and a frame is `FRAME_PIXELS` pixels long (324 by default). The host cannot keep up with the stream. The block therefore latches just one pixel per frame. That pixel is the one whose position in the frame equals an internal index pointer. The held value is presented on the read bus until the host accesses the register again.

Each access arms the grabber. An armed grabber ignores the rest of any frame already under way. It waits for the next frame-start marker and latches the pixel at the pointer's position. A read that finds a latched pixel returns it and steps the pointer on by one. A read that finds no pixel yet returns zero and leaves the pointer where it is. A write restarts the dump at the first pixel. Dumping a full image therefore costs at least one frame per pixel. The value handed back may come from a frame that ended long before the read.

Top module: `pixel_dump_reg`

## Requirements
- R1: The read word is `{first, valid, pixel[5:0]}`. Bit 7 (first) is set only when the word is valid and holds frame position 0. Bit 6 (valid) is set when a latched pixel is held. Bits 5:0 carry the latched 6-bit value and read as zero when not valid.
- R2: After reset the read word is 0x00, the pointer is at position 0, and the grabber is not armed until the first access.
- R3: A write, whatever its data, sets the pointer to position 0, discards any held pixel and arms the grabber. The next valid read returns frame position 0 with bit 7 set.
- R4: A read that returns a valid word advances the pointer by one position and re-arms the grabber. Successive valid reads return consecutive frame positions.
- R5: The pointer wraps from position `FRAME_PIXELS-1` to 0. After 324 valid reads following a write, the 325th valid read returns position 0 with bit 7 set.
- R6: Once armed, the grabber captures only from a frame whose start marker arrives after the arming access. Pixels of a frame already in progress are never latched.
- R7: A read while no pixel is held returns 0x00 and leaves the pointer unchanged. It arms the grabber if it was not armed and does not restart an armed grabber.
- R8: A latched pixel is captured once and then held unchanged on the read bus through any number of later frames until the next access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for stream and register side |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | A pixel is present on the stream this cycle |
| pix_sof | input | 1 | This pixel is position 0 of a new frame (qualified by pix_valid) |
| pix_data | input | 6 | Pixel value |
| rd_stb | input | 1 | Register read; the word on rd_data in this cycle is the one read |
| wr_stb | input | 1 | Register write (data ignored) |
| rd_data | output | 8 | Read word: first flag, valid flag, pixel |

## Verification
The main loop tries four stream patterns: a ramp that changes with both position and frame number, all-ones, all-zeros and an alternating pair. The ramp shows which frame and which position were latched. All-zeros separates a valid zero pixel (0x40) from an empty read (0x00). All-ones and the alternating pattern expose stuck or swapped data bits. Directed tests then cover the following:
- an empty read, which must not move the pointer;
- data held across three idle frames;
- a read issued partway through a frame, after which only the next frame may supply the pixel;
- a complete 325-read dump that must wrap to position 0 with the first flag set.

// File: rtl/pixel_dump_pkg.sv
package pixel_dump_pkg;

  localparam int PIX_W  = 6;
  localparam int WORD_W = PIX_W + 2;

  typedef enum logic [1:0] {
    GRAB_IDLE = 2'd0,
    GRAB_WAIT = 2'd1,
    GRAB_HUNT = 2'd2,
    GRAB_HELD = 2'd3
  } grab_state_e;

  // Next pointer position with wrap at the frame length.
  function automatic int unsigned ptr_step(int unsigned cur, int unsigned frame_len);
    if (cur + 1 >= frame_len) return 0;
    return cur + 1;
  endfunction

  // Register word: first flag, valid flag, pixel (zero when empty).
  function automatic logic [WORD_W-1:0] pack_word(logic held, logic at_first,
                                                  logic [PIX_W-1:0] pix);
    return {held & at_first, held, held ? pix : {PIX_W{1'b0}}};
  endfunction

endpackage

// File: rtl/frame_pos_tracker.sv
module frame_pos_tracker #(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic             pix_sof,
  output logic [IDX_W-1:0] cur_idx
);
  logic [IDX_W-1:0] pos_q;

  // Before the first start marker the position is parked at all-ones,
  // which is never a legal pointer value.
  assign cur_idx = pix_sof ? '0 : pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '1;
    end else if (pix_valid) begin
      if (cur_idx == '1) pos_q <= cur_idx;
      else               pos_q <= cur_idx + 1'b1;
    end
  end
endmodule

// File: rtl/dump_pointer.sv
module dump_pointer
  import pixel_dump_pkg::*;
#(
  parameter int FRAME_PIXELS = 324,
  parameter int IDX_W        = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr_q
);
  logic [IDX_W-1:0] ptr_nx;

  always_comb begin
    ptr_nx = ptr_q;
    if (clear)        ptr_nx = '0;
    else if (advance) ptr_nx = IDX_W'(ptr_step(32'(ptr_q), 32'(FRAME_PIXELS)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_nx;
  end
endmodule

// File: rtl/grab_ctrl.sv
module grab_ctrl
  import pixel_dump_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stb,
  input  logic             wr_stb,
  input  logic             pix_valid,
  input  logic             pix_sof,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             idx_match,
  output logic             held,
  output logic [PIX_W-1:0] pix_q,
  output logic             restart,
  output logic             capture_fire
);
  grab_state_e state_q, state_nx;
  logic        searching;

  assign held = (state_q == GRAB_HELD);

  // An access restarts the search unless a search is already running
  // and the access is a read (an empty read leaves it alone).
  assign restart = wr_stb | (rd_stb & (state_q == GRAB_HELD || state_q == GRAB_IDLE));

  assign searching = (state_q == GRAB_HUNT) || (state_q == GRAB_WAIT && pix_sof);
  assign capture_fire = !restart && pix_valid && searching && idx_match;

  always_comb begin
    state_nx = state_q;
    if (restart) begin
      state_nx = GRAB_WAIT;
    end else if (capture_fire) begin
      state_nx = GRAB_HELD;
    end else if (state_q == GRAB_WAIT && pix_valid && pix_sof) begin
      state_nx = GRAB_HUNT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= GRAB_IDLE;
      pix_q   <= '0;
    end else begin
      state_q <= state_nx;
      if (restart)           pix_q <= '0;
      else if (capture_fire) pix_q <= pix_data;
    end
  end
endmodule

// File: rtl/pixel_dump_reg.sv
module pixel_dump_reg
  import pixel_dump_pkg::*;
#(
  parameter int FRAME_PIXELS = 324
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic              pix_sof,
  input  logic [5:0]        pix_data,
  input  logic              rd_stb,
  input  logic              wr_stb,
  output logic [7:0]        rd_data
);
  localparam int IDX_W = $clog2(FRAME_PIXELS + 1);

  logic [IDX_W-1:0] cur_idx;
  logic [IDX_W-1:0] ptr_q;
  logic             idx_match;
  logic             held;
  logic [PIX_W-1:0] pix_q;
  logic             restart;
  logic             capture_fire;
  logic             ptr_advance;

  frame_pos_tracker #(.IDX_W(IDX_W)) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_valid(pix_valid),
    .pix_sof  (pix_sof),
    .cur_idx  (cur_idx)
  );

  assign idx_match   = (cur_idx == ptr_q);
  assign ptr_advance = rd_stb & ~wr_stb & held;

  dump_pointer #(.FRAME_PIXELS(FRAME_PIXELS), .IDX_W(IDX_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (wr_stb),
    .advance(ptr_advance),
    .ptr_q  (ptr_q)
  );

  grab_ctrl u_grab (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_stb      (rd_stb),
    .wr_stb      (wr_stb),
    .pix_valid   (pix_valid),
    .pix_sof     (pix_sof),
    .pix_data    (pix_data),
    .idx_match   (idx_match),
    .held        (held),
    .pix_q       (pix_q),
    .restart     (restart),
    .capture_fire(capture_fire)
  );

  assign rd_data = pack_word(held, ptr_q == '0, pix_q);
endmodule

// File: rtl/pixel_dump_reg_chk.sv
module pixel_dump_reg_chk #(
  parameter int FRAME_PIXELS = 324,
  parameter int IDX_W        = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_stb,
  input logic             wr_stb,
  input logic             pix_valid,
  input logic [7:0]       rd_data,
  input logic [IDX_W-1:0] ptr_q,
  input logic             capture_fire
);
  // R1: first flag only on a valid word
  p_first_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] |-> rd_data[6]);

  // R1: empty word carries no pixel bits
  p_empty_is_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[6] |-> (rd_data == 8'h00));

  // R3: a write empties the register and sends the pointer home
  p_write_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (!rd_data[6] && ptr_q == '0));

  // R4 / R5: a valid read moves the pointer one step with wrap
  p_valid_read_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb && rd_data[6]) |=>
      ptr_q == (($past(ptr_q) == IDX_W'(FRAME_PIXELS-1)) ? '0 : $past(ptr_q) + 1'b1));

  // R5: the pointer never leaves the frame
  p_ptr_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q < IDX_W'(FRAME_PIXELS));

  // R7: an empty read does not move the pointer
  p_empty_read_holds_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb && !rd_data[6]) |=> $stable(ptr_q));

  // R8: held data stays put while the host is silent
  p_held_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[6] && !rd_stb && !wr_stb) |=> $stable(rd_data));

  // R8: a capture needs a stream pixel and ends with a valid word
  p_capture_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture_fire |-> pix_valid ##1 rd_data[6]);
endmodule

bind pixel_dump_reg pixel_dump_reg_chk #(
  .FRAME_PIXELS(FRAME_PIXELS),
  .IDX_W       (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_stb      (rd_stb),
  .wr_stb      (wr_stb),
  .pix_valid   (pix_valid),
  .rd_data     (rd_data),
  .ptr_q       (ptr_q),
  .capture_fire(capture_fire)
);

// File: tb/pixel_dump_reg_bench.sv
`timescale 1ns/1ps
module pixel_dump_reg_bench;
  localparam int FP = 324;
  localparam int NVEC = 4;
  // Stream pattern per table entry: 0 ramp, 1 all ones, 2 all zeros, 3 alternating
  localparam logic [1:0] VEC_MODE [NVEC] = '{2'd0, 2'd1, 2'd2, 2'd3};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_valid = 1'b0;
  logic       pix_sof = 1'b0;
  logic [5:0] pix_data = '0;
  logic       rd_stb = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] rd_data;

  int errors = 0;
  int checks = 0;
  int frame_no = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pixel_dump_reg #(.FRAME_PIXELS(FP)) u_pixel_dump_reg (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_data(pix_data), .rd_stb(rd_stb), .wr_stb(wr_stb), .rd_data(rd_data)
  );

  function automatic logic [5:0] pat(int mode, int fr, int idx);
    case (mode)
      0:       return 6'((idx * 5 + fr * 3) % 64);
      1:       return 6'd63;
      2:       return 6'd0;
      default: return (idx % 2 == 1) ? 6'd42 : 6'd21;
    endcase
  endfunction

  function automatic logic [7:0] want(int mode, int fr, int idx);
    return {(idx == 0), 1'b1, pat(mode, fr, idx)};
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic send_frame(int mode);
    for (int i = 0; i < FP; i++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      pix_sof   = (i == 0);
      pix_data  = pat(mode, frame_no, i);
    end
    @(negedge clk);
    pix_valid = 1'b0;
    pix_sof   = 1'b0;
    frame_no++;
  endtask

  task automatic do_read(output logic [7:0] w);
    @(negedge clk);
    rd_stb = 1'b1;
    #1 w = rd_data;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic do_write();
    @(negedge clk);
    wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] w;
    int f0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R2 reset word", rd_data, 8'h00);

    // R7 / R2: empty read before any frame, then it arms without moving the pointer
    do_read(w);
    check("R7 empty read after reset", w, 8'h00);
    f0 = frame_no;
    send_frame(0);
    do_read(w);
    check("R7 pointer unmoved by empty read", w, want(0, f0, 0));

    // Table walk: R1 R3 R4 across stream patterns
    for (int v = 0; v < NVEC; v++) begin
      do_write();
      do_read(w);
      check("R3 empty after write", w, 8'h00);
      for (int k = 0; k < 3; k++) begin
        f0 = frame_no;
        send_frame(int'(VEC_MODE[v]));
        do_read(w);
        check((k == 0) ? "R3 first pixel after write" : "R4 next position", w,
              want(int'(VEC_MODE[v]), f0, k));
      end
    end

    // R8: stale data survives later frames
    do_write();
    f0 = frame_no;
    send_frame(0);
    send_frame(0);
    send_frame(0);
    #1 check("R8 held through idle frames", rd_data, want(0, f0, 0));
    do_read(w);
    check("R8 old frame returned", w, want(0, f0, 0));

    // R6: read issued partway through a frame; that frame must be skipped
    f0 = frame_no;
    send_frame(0);            // latches position 1
    fork
      send_frame(0);
      begin
        repeat (2) @(negedge clk);
        do_read(w);
      end
    join
    check("R6 mid-frame read returns prior capture", w, want(0, f0, 1));
    f0 = frame_no;
    send_frame(0);
    do_read(w);
    check("R6 capture from next full frame", w, want(0, f0, 2));

    // R5: full dump with wrap on the 325th read
    do_write();
    for (int i = 0; i <= FP; i++) begin
      f0 = frame_no;
      send_frame(0);
      do_read(w);
      if (i == FP) check("R5 wrap returns position 0", w, want(0, f0, 0));
      else if (i == FP - 1) check("R5 last position", w, want(0, f0, FP - 1));
      else check("R4 dump position", w, want(0, f0, i));
    end

    // R3: write discards a held pixel
    send_frame(1);
    do_write();
    #1 check("R3 write discards held pixel", rd_data, 8'h00);

    finish_run();
  end
endmodule